// File: doc/BRIEF.md
# Uncached Indexed Load/Store Unit

This block carries out the cache-bypassing indexed memory operations of a 64-bit core. It handles loads and stores of 1, 2, 4 and 8 bytes. Each operation arrives already decoded, with these fields:

- the access size and a store flag;
- the number of the base register and the base, index and source register values;
- the number of the destination register.

The unit works out the effective address and checks its alignment. It then places one request on a simple memory bus that uses a valid/ready handshake. For a load, it returns the zero-extended result together with a one-cycle writeback strobe.

A base register number of zero stands for a literal zero, so the base register value is then ignored. Memory is big-endian within an 8-byte bus lane. The byte at lane offset k travels on data bits [63-8k:56-8k] and is enabled by byte-enable bit 7-k. An operation whose address is not a multiple of its size raises a one-cycle alignment fault and never reaches the bus. The unit holds one operation at a time and accepts the next only after the current one has completed.

Top module: `uncached_ldst_unit`

## Requirements
- R1: When `raNum` is 0 the base is zero and `raVal` has no effect on the address. Otherwise the base is `raVal`.
- R2: The effective address `busAddr` is base plus `rbVal`, a 64-bit sum that wraps on overflow.
- R3: Size code 0, 1, 2 and 3 means 1, 2, 4 and 8 bytes, and `busSize` carries that code. Byte-enable bit 7-k is set exactly for lane offsets k inside the access, where k runs from `busAddr[2:0]` to `busAddr[2:0]` plus the size minus one.
- R4: A store sends the low 1, 2, 4 or all 8 bytes of `rsVal` with `busWrite` high. The most significant of those bytes sits at the lowest lane offset.
- R5: A load of 1, 2 or 4 bytes returns the enabled lane bytes in big-endian order, with the upper 56, 48 or 32 result bits zero.
- R6: An 8-byte load returns all 64 bits of `busRdata` unchanged.
- R7: A misaligned operation raises `alignFault` for exactly the cycle after acceptance and issues no bus request.
- R8: While `busValid` is high and `busReady` is low, `busAddr`, `busSize`, `busByteEn`, `busWrite` and `busWdata` stay stable.
- R9: Each aligned operation makes exactly one bus transaction. `opReady` is low from acceptance until the bus handshake, and `opValid` is ignored during that time.
- R10: A load raises `wbValid` for exactly one cycle, the cycle after the handshake, with `wbRt` equal to `rtNum`. A store never raises `wbValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation offered |
| opReady | output | 1 | Unit is idle and can accept an operation |
| opSize | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| opIsStore | input | 1 | 1 = store, 0 = load |
| raNum | input | 5 | Base register number (0 means a literal zero) |
| raVal | input | 64 | Base register value |
| rbVal | input | 64 | Index register value |
| rsVal | input | 64 | Store source register value |
| rtNum | input | 5 | Load destination register number |
| busValid | output | 1 | Bus request valid |
| busReady | input | 1 | Bus acknowledge |
| busAddr | output | 64 | Effective address |
| busSize | output | 2 | Size code of the request |
| busByteEn | output | 8 | Byte enables, bit 7-k for lane offset k |
| busWrite | output | 1 | Request is a write |
| busWdata | output | 64 | Write data in big-endian lane order |
| busRdata | input | 64 | Read data, valid with busReady |
| wbValid | output | 1 | Load result writeback strobe |
| wbRt | output | 5 | Writeback destination register |
| wbData | output | 64 | Zero-extended load result |
| alignFault | output | 1 | Misaligned operation rejected |

## Verification
The embedded assertions watch properties that must hold on every cycle:

- the request stays stable while it waits for `busReady`;
- the byte-enable count matches the size, and every address on the bus is aligned;
- the writeback strobe lasts one cycle and never follows a store handshake;
- a fault never coincides with a bus request.

Some behaviour only the bench's scenarios can show. These are the arithmetic of the address (the zero base and wraparound), the placement of each byte in its lane, and the extraction and zero-fill of load data. The same holds for one transaction per operation while `opValid` is held through a stall.

// File: rtl/uli_pkg.sv
package uli_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_t;

  typedef struct packed {
    logic capture;   // accept an aligned operation into the request registers
    logic loadDone;  // bus handshake of a load: latch result and strobe
  } uli_strobe_t;
endpackage

// File: rtl/uli_ctrl.sv
module uli_ctrl
  import uli_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic        misaligned,
  input  logic        storeQ,
  input  logic        busReady,
  output logic        opReady,
  output logic        busValid,
  output logic        alignFault,
  output uli_strobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_BUS} state_t;
  state_t state;

  logic accept;
  logic complete;

  assign opReady  = (state == ST_IDLE);
  assign busValid = (state == ST_BUS);
  assign accept   = opValid && opReady;
  assign complete = busValid && busReady;

  always_comb begin
    strobe = '0;
    strobe.capture  = accept && !misaligned;
    strobe.loadDone = complete && !storeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      alignFault <= 1'b0;
    end else begin
      alignFault <= accept && misaligned;
      case (state)
        ST_IDLE: if (accept && !misaligned) state <= ST_BUS;
        ST_BUS:  if (busReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a rejected operation never leaves a request on the bus
  assert_fault_no_bus_R7: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !busValid);

  // R9: a completed handshake always returns the unit to idle
  assert_single_txn_R9: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> opReady && !busValid);
endmodule

// File: rtl/uli_datapath.sv
module uli_datapath
  import uli_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_IDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  uli_strobe_t          strobe,
  input  logic [1:0]           opSize,
  input  logic                 opIsStore,
  input  logic [REG_IDX_W-1:0] raNum,
  input  logic [DATA_W-1:0]    raVal,
  input  logic [DATA_W-1:0]    rbVal,
  input  logic [DATA_W-1:0]    rsVal,
  input  logic [REG_IDX_W-1:0] rtNum,
  input  logic [DATA_W-1:0]    busRdata,
  output logic                 misaligned,
  output logic                 storeQ,
  output logic [DATA_W-1:0]    addrQ,
  output logic [1:0]           sizeQ,
  output logic [DATA_W/8-1:0]  beQ,
  output logic [DATA_W-1:0]    wdataQ,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbRt,
  output logic [DATA_W-1:0]    wbData
);
  localparam int LANE_BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANE_BYTES);
  localparam int BSH_W = OFF_W + 1;
  localparam logic [BSH_W-1:0] LANE_CNT = BSH_W'(LANE_BYTES);

  logic [DATA_W-1:0]    base;
  logic [DATA_W-1:0]    ea;
  logic [OFF_W-1:0]     offNew;
  logic [BSH_W-1:0]     nBytesNew;
  logic [BSH_W-1:0]     nBytesQ;
  logic [BSH_W-1:0]     shiftNew;
  logic [BSH_W-1:0]     shiftQ;
  logic [DATA_W-1:0]    lowMaskNew;
  logic [DATA_W-1:0]    lowMaskQ;
  logic [LANE_BYTES-1:0] beLowNew;
  logic [REG_IDX_W-1:0] rtQ;

  function automatic logic [DATA_W-1:0] byteMask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANE_BYTES; i++)
      if (i < (1 << sz)) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [LANE_BYTES-1:0] enableMask(input logic [1:0] sz);
    logic [LANE_BYTES-1:0] m;
    m = '0;
    for (int i = 0; i < LANE_BYTES; i++)
      if (i < (1 << sz)) m[i] = 1'b1;
    return m;
  endfunction

  // R1, R2: zero base for register number zero, wrapping sum
  assign base       = (raNum == '0) ? '0 : raVal;
  assign ea         = base + rbVal;
  assign offNew     = ea[OFF_W-1:0];
  assign nBytesNew  = BSH_W'(1) << opSize;
  assign lowMaskNew = byteMask(opSize);
  assign beLowNew   = enableMask(opSize);
  assign misaligned = |(BSH_W'(offNew) & (nBytesNew - BSH_W'(1)));
  // byte distance from the access's last byte to lane bit 0 (big-endian)
  assign shiftNew   = LANE_CNT - BSH_W'(offNew) - nBytesNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      sizeQ    <= '0;
      storeQ   <= 1'b0;
      beQ      <= '0;
      wdataQ   <= '0;
      rtQ      <= '0;
      shiftQ   <= '0;
      nBytesQ  <= '0;
      lowMaskQ <= '0;
    end else if (strobe.capture) begin
      addrQ    <= ea;
      sizeQ    <= opSize;
      storeQ   <= opIsStore;
      beQ      <= beLowNew << shiftNew;
      wdataQ   <= opIsStore ? ((rsVal & lowMaskNew) << {shiftNew, 3'b000}) : '0;
      rtQ      <= rtNum;
      shiftQ   <= shiftNew;
      nBytesQ  <= nBytesNew;
      lowMaskQ <= lowMaskNew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
      wbRt    <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= strobe.loadDone;
      if (strobe.loadDone) begin
        wbRt   <= rtQ;
        wbData <= (busRdata >> {shiftQ, 3'b000}) & lowMaskQ;
      end
    end
  end

  // R10: writeback strobe lasts exactly one cycle
  assert_wb_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid);

  // R3: captured lane count matches the captured size code
  assert_lane_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(beQ) == int'(nBytesQ) || nBytesQ == '0);
endmodule

// File: rtl/uncached_ldst_unit.sv
module uncached_ldst_unit
  import uli_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  output logic        opReady,
  input  logic [1:0]  opSize,
  input  logic        opIsStore,
  input  logic [4:0]  raNum,
  input  logic [63:0] raVal,
  input  logic [63:0] rbVal,
  input  logic [63:0] rsVal,
  input  logic [4:0]  rtNum,
  output logic        busValid,
  input  logic        busReady,
  output logic [63:0] busAddr,
  output logic [1:0]  busSize,
  output logic [7:0]  busByteEn,
  output logic        busWrite,
  output logic [63:0] busWdata,
  input  logic [63:0] busRdata,
  output logic        wbValid,
  output logic [4:0]  wbRt,
  output logic [63:0] wbData,
  output logic        alignFault
);
  uli_strobe_t strobe;
  logic misaligned;
  logic storeQ;

  uli_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .misaligned(misaligned),
    .storeQ(storeQ), .busReady(busReady), .opReady(opReady),
    .busValid(busValid), .alignFault(alignFault), .strobe(strobe)
  );

  uli_datapath #(.DATA_W(64), .REG_IDX_W(5)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSize(opSize),
    .opIsStore(opIsStore), .raNum(raNum), .raVal(raVal), .rbVal(rbVal),
    .rsVal(rsVal), .rtNum(rtNum), .busRdata(busRdata),
    .misaligned(misaligned), .storeQ(storeQ), .addrQ(busAddr),
    .sizeQ(busSize), .beQ(busByteEn), .wdataQ(busWdata),
    .wbValid(wbValid), .wbRt(wbRt), .wbData(wbData)
  );

  assign busWrite = storeQ;

  // R8: request fields hold while waiting for the acknowledge
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busSize)
      && $stable(busByteEn) && $stable(busWrite) && $stable(busWdata));

  // R3: enabled byte count equals the request size
  assert_be_size_R3: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> $countones(busByteEn) == (1 << busSize));

  // R7: only aligned addresses ever reach the bus
  assert_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr[2:0] & ((3'd1 << busSize) - 3'd1)) == 3'd0);

  // R10: a store handshake produces no writeback
  assert_store_no_wb_R10: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busReady && busWrite |=> !wbValid);
endmodule

// File: tb/tb_uncached_ldst_unit.sv
module tb_uncached_ldst_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0, opIsStore = 1'b0, busReady = 1'b0;
  logic [1:0] opSize = '0;
  logic [4:0] raNum = '0, rtNum = '0;
  logic [63:0] raVal = '0, rbVal = '0, rsVal = '0, busRdata = '0;
  logic opReady, busValid, busWrite, wbValid, alignFault;
  logic [63:0] busAddr, busWdata, wbData;
  logic [1:0] busSize;
  logic [7:0] busByteEn;
  logic [4:0] wbRt;

  int checks = 0;
  int fails = 0;
  int txCount = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  uncached_ldst_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady),
    .opSize(opSize), .opIsStore(opIsStore), .raNum(raNum), .raVal(raVal),
    .rbVal(rbVal), .rsVal(rsVal), .rtNum(rtNum), .busValid(busValid),
    .busReady(busReady), .busAddr(busAddr), .busSize(busSize),
    .busByteEn(busByteEn), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .wbValid(wbValid), .wbRt(wbRt), .wbData(wbData),
    .alignFault(alignFault)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (busValid && busReady) txCount <= txCount + 1;
  end

  typedef struct packed {
    logic [1:0]  sz;
    logic        st;
    logic [4:0]  ra;
    logic [63:0] raV;
    logic [63:0] rbV;
    logic [63:0] rsV;
    logic [63:0] rd;
    logic [2:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 5'd3, 64'h1000, 64'h5, 64'h0, 64'h0011223344556677, 3'd0},
    '{2'd1, 1'b0, 5'd0, 64'hDEAD, 64'h2006, 64'h0, 64'h8899AABBCCDDEEFF, 3'd2},
    '{2'd2, 1'b0, 5'd7, 64'hFFFFFFFFFFFFFFFC, 64'h8, 64'h0, 64'hF0E1D2C3B4A59687, 3'd1},
    '{2'd3, 1'b0, 5'd1, 64'h100, 64'h8, 64'h0, 64'h0123456789ABCDEF, 3'd3},
    '{2'd0, 1'b1, 5'd2, 64'h3000, 64'h0, 64'hAABBCCDDEEFF0123, 64'h0, 3'd1},
    '{2'd1, 1'b1, 5'd0, 64'h55, 64'h4002, 64'h1122334455667788, 64'h0, 3'd0},
    '{2'd2, 1'b1, 5'd4, 64'h10, 64'h4, 64'hCAFEF00DDEADBEEF, 64'h0, 3'd2},
    '{2'd3, 1'b1, 5'd9, 64'h7FF0, 64'h10, 64'h0F1E2D3C4B5A6978, 64'h0, 3'd1},
    '{2'd1, 1'b0, 5'd5, 64'h20, 64'h1, 64'h0, 64'h0, 3'd0},
    '{2'd2, 1'b1, 5'd6, 64'h40, 64'h2, 64'h12345678, 64'h0, 3'd0},
    '{2'd3, 1'b0, 5'd0, 64'h4, 64'hC, 64'h0, 64'h0, 3'd0},
    '{2'd0, 1'b0, 5'd8, 64'h5000, 64'h7, 64'h0, 64'hA1B2C3D4E5F60718, 3'd1}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expEa(input logic [4:0] ra,
                                        input logic [63:0] a, input logic [63:0] b);
    return (ra == 5'd0 ? 64'd0 : a) + b;
  endfunction

  task automatic runOp(input vec_t v, input logic [4:0] rt);
    logic [63:0] ea, expW, expR;
    logic [7:0] expBe;
    int n, off, startTx;
    bit bad;
    ea = expEa(v.ra, v.raV, v.rbV);
    n = 1 << v.sz;
    off = int'(ea[2:0]);
    bad = (ea % n) != 0;
    expBe = '0; expW = '0; expR = '0;
    for (int k = 0; k < 8; k++)
      if (k >= off && k < off + n) expBe[7-k] = 1'b1;
    for (int i = 0; i < n && i + off < 8; i++) begin
      expW[8*(7-(off+i)) +: 8] = v.rsV[8*(n-1-i) +: 8];
      expR[8*(n-1-i) +: 8] = v.rd[8*(7-(off+i)) +: 8];
    end
    startTx = txCount;
    @(negedge clk);
    chk("R9", "opReady idle", {63'd0, opReady}, 64'd1);
    opValid = 1; opSize = v.sz; opIsStore = v.st; raNum = v.ra;
    raVal = v.raV; rbVal = v.rbV; rsVal = v.rsV; rtNum = rt;
    @(negedge clk);
    if (bad) begin
      opValid = 0;
      chk("R7", "alignFault", {63'd0, alignFault}, 64'd1);
      chk("R7", "no busValid", {63'd0, busValid}, 64'd0);
      @(negedge clk);
      chk("R7", "fault one cycle", {63'd0, alignFault}, 64'd0);
      chk("R7", "no transaction", 64'(txCount - startTx), 64'd0);
      return;
    end
    chk("R7", "no fault", {63'd0, alignFault}, 64'd0);
    chk("R9", "busValid", {63'd0, busValid}, 64'd1);
    chk("R2", "address", busAddr, ea);
    chk("R3", "busSize", {62'd0, busSize}, {62'd0, v.sz});
    chk("R3", "byte enables", {56'd0, busByteEn}, {56'd0, expBe});
    chk("R4", "busWrite", {63'd0, busWrite}, {63'd0, v.st});
    if (v.st) chk("R4", "write data", busWdata, expW);
    for (int w = 0; w < int'(v.lat); w++) begin
      @(negedge clk);
      chk("R9", "busy not ready", {63'd0, opReady}, 64'd0);
      chk("R8", "held address", busAddr, ea);
      chk("R8", "held enables", {56'd0, busByteEn}, {56'd0, expBe});
    end
    busReady = 1; busRdata = v.rd;
    @(negedge clk);
    busReady = 0; opValid = 0; busRdata = '0;
    chk("R9", "bus released", {63'd0, busValid}, 64'd0);
    chk("R9", "one transaction", 64'(txCount - startTx), 64'd1);
    chk("R10", "wbValid", {63'd0, wbValid}, {63'd0, !v.st});
    if (!v.st) begin
      chk("R10", "wbRt", {59'd0, wbRt}, {59'd0, rt});
      chk(v.sz == 2'd3 ? "R6" : "R5", "load data", wbData, expR);
    end
    @(negedge clk);
    chk("R10", "wb one cycle", {63'd0, wbValid}, 64'd0);
    chk("R9", "no extra transaction", 64'(txCount - startTx), 64'd1);
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk("R9", "reset opReady", {63'd0, opReady}, 64'd1);
    chk("R9", "reset busValid", {63'd0, busValid}, 64'd0);
    chk("R10", "reset wbValid", {63'd0, wbValid}, 64'd0);
    chk("R7", "reset alignFault", {63'd0, alignFault}, 64'd0);
    rstN = 1;
    for (int i = 0; i < NV; i++) runOp(VECS[i], 5'(i + 1));
    // R1: base register value ignored for register number zero
    v = '{2'd3, 1'b0, 5'd0, 64'hFFFF0000, 64'h88, 64'h0, 64'h5A5A5A5AA5A5A5A5, 3'd0};
    runOp(v, 5'd31);
    v.raV = 64'h123458;
    runOp(v, 5'd30);
    // R2: wraparound to address zero
    v = '{2'd2, 1'b1, 5'd11, 64'hFFFFFFFFFFFFFFF0, 64'h10, 64'hFFFFFFFF89ABCDEF, 64'h0, 3'd1};
    runOp(v, 5'd2);
    done = 1;
  end

  initial begin
    wait (done || cycles > 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule